// File: doc/BRIEF.md
# Bit-Slice Adaptive FIR Filter

This block is a sixteen-tap adaptive FIR filter that contains no multiplier and no table of precomputed coefficient sums. Samples sit in a tap delay line. For each bit position of those samples, one clock cycle adds together every weight whose sample has that bit set. A shifting accumulator combines these slice sums into the filter output. The block then compares the output against a desired value supplied with the sample. The resulting error drives a least-mean-squares correction of every weight. That correction is also done bit-serially, with one small accumulator per tap, so all weights are updated in the same sixteen cycles.

A host presents one sample and its desired value with a one-cycle valid strobe. Roughly one new sample every 200 cycles is the intended rate, but the block is ready again much sooner. Samples that arrive while the block is still working are dropped, and a sticky flag records that this happened. The step size of the update is a power of two, chosen by a parameter.

Top module: `dalms_fir`

## Requirements
- R1: After synchronous reset, out_valid, out_y, out_err and overrun are 0. All weights and delay-line entries are zero, so the first output after reset is 0 and its error equals the desired value.
- R2: A sample is accepted on a rising edge where in_valid is 1 and the block is idle. out_valid is then 1 for exactly one cycle, set by the DW-th edge after the accepting edge (16 by default). out_y and out_err change only together with out_valid.
- R3: The accepted sample becomes tap 0 and older samples move one tap further. All values are two's complement. out_y = sat16(floor(sum over k of w[k]*x[k] / 2^15)), using the weights in force before this sample's update.
- R4: out_err = sat16(d - out_y), where d is in_desired captured on the accepting edge.
- R5: Before the next sample is accepted, each weight becomes sat16(w[k] + floor(out_err * x[k] / 2^(15+MU_SHIFT))). The x[k] values are the delay-line contents used for that output, and MU_SHIFT is 2 by default.
- R6: in_valid on any edge while the block is busy is ignored: the delay line, weights and outputs are untouched and no output is produced. overrun is set to 1 and stays 1 until reset.
- R7: The block is busy for 2*DW edges after an accepting edge, so a new sample is accepted at the earliest on edge 2*DW+1 (33 by default).
- R8: sat16 clamps to the range -32768..32767. This applies to the output, to the error and to every stored weight, including when a sample of -32768 is in the delay line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | DW | Input sample, two's complement |
| in_desired | input | DW | Desired value for this sample |
| out_valid | output | 1 | One-cycle result strobe |
| out_y | output | DW | Filter output |
| out_err | output | DW | Desired minus output, saturated |
| overrun | output | 1 | Sticky: a sample arrived while busy |

## Verification
Each accepted sample gives one result, due exactly 16 edges after the accepting edge. The adapted weights affect only the next result, which the block can accept 33 edges after the previous one. The driver records the edge count at acceptance and pushes the due edge, output and error into a queue. The monitor samples on falling edges, and whenever out_valid is seen it checks the edge count against the due value before comparing data. Dropped samples push nothing, so any result they caused would show up as an unexpected pop.

// File: rtl/dalms_pkg.sv
package dalms_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_FILT = 2'd1,
      ST_UPD  = 2'd2
   } dalms_state_t;

   // spare sign bits kept above the largest accumulator magnitude
   localparam int DALMS_GUARD = 3;

endpackage

// File: rtl/dalms_sat.sv
module dalms_sat #(
   parameter int IW = 24,
   parameter int OW = 16
) (
   input  logic signed [IW-1:0] din,
   output logic signed [OW-1:0] dout
);
   localparam logic signed [IW-1:0] HI = IW'((64'sd1 <<< (OW - 1)) - 64'sd1);
   localparam logic signed [IW-1:0] LO = ~HI;

   if (IW <= OW) begin : g_bad_width
      $error("dalms_sat: input must be wider than output");
   end

   always_comb begin
      if (din > HI)      dout = HI[OW-1:0];
      else if (din < LO) dout = LO[OW-1:0];
      else               dout = din[OW-1:0];
   end
endmodule

// File: rtl/dalms_slice_sum.sv
module dalms_slice_sum #(
   parameter int TAPS = 16,
   parameter int WW   = 16,
   parameter int AW   = 24
) (
   input  logic [TAPS-1:0][WW-1:0] wgt,
   input  logic [TAPS-1:0]         sel,
   output logic signed [AW-1:0]    sum
);
   logic signed [AW-1:0] part [TAPS+1];

   if (AW <= WW) begin : g_bad_width
      $error("dalms_slice_sum: sum must be wider than a weight");
   end

   assign part[0] = '0;

   for (genvar k = 0; k < TAPS; k++) begin : g_tap
      logic signed [AW-1:0] term;
      assign term       = sel[k] ? {{(AW-WW){wgt[k][WW-1]}}, wgt[k]} : '0;
      assign part[k+1]  = part[k] + term;
   end

   assign sum = part[TAPS];
endmodule

// File: rtl/dalms_shift_acc.sv
module dalms_shift_acc #(
   parameter int AW = 24
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 clr,
   input  logic                 en,
   input  logic                 last,
   input  logic signed [AW-1:0] addend,
   output logic signed [AW-1:0] acc_d
);
   import dalms_pkg::*;

   logic signed [AW-1:0] acc_q;
   logic signed [AW-1:0] sum_v;

   if (AW <= DALMS_GUARD + 1) begin : g_bad_width
      $error("dalms_shift_acc: accumulator too narrow");
   end

   // lower bits add and halve; the sign slice subtracts without halving
   assign sum_v = acc_q + addend;
   assign acc_d = last ? (acc_q - addend) : (sum_v >>> 1);

   always_ff @(posedge clk) begin
      if (rst || clr) acc_q <= '0;
      else if (en)    acc_q <= acc_d;
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      (&acc_q[AW-1:AW-DALMS_GUARD]) || !(|acc_q[AW-1:AW-DALMS_GUARD]))
      else $error("accumulator headroom lost"); // R3
endmodule

// File: rtl/dalms_fir.sv
module dalms_fir #(
   parameter int TAPS     = 16,
   parameter int DW       = 16,
   parameter int WW       = 16,
   parameter int AW       = 24,
   parameter int MU_SHIFT = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_valid,
   input  logic [DW-1:0] in_sample,
   input  logic [DW-1:0] in_desired,
   output logic          out_valid,
   output logic [DW-1:0] out_y,
   output logic [DW-1:0] out_err,
   output logic          overrun
);
   import dalms_pkg::*;

   localparam int            CW       = $clog2(DW);
   localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

   if (TAPS < 2) begin : g_bad_taps
      $error("dalms_fir: at least two taps required");
   end
   if (AW < WW + $clog2(TAPS) + 4) begin : g_bad_aw_filt
      $error("dalms_fir: accumulator too narrow for slice sums");
   end
   if (AW < DW + 4) begin : g_bad_aw_upd
      $error("dalms_fir: accumulator too narrow for error products");
   end
   if (MU_SHIFT < 0 || MU_SHIFT >= AW) begin : g_bad_mu
      $error("dalms_fir: step shift out of range");
   end

   dalms_state_t                 state;
   logic [CW-1:0]                bit_cnt;
   logic [TAPS-1:0][DW-1:0]      xdl;
   logic [TAPS-1:0][WW-1:0]      wgt;
   logic [DW-1:0]                d_q;

   logic                         accept;
   logic                         busy;
   logic                         bit_last;
   logic                         filt_done;
   logic [TAPS-1:0]              x_slice;
   logic signed [AW-1:0]         s_slice;
   logic signed [AW-1:0]         facc_d;
   logic signed [DW-1:0]         y_next;
   logic signed [DW:0]           e_wide;
   logic signed [DW-1:0]         e_next;
   logic [WW-1:0]                w_new [TAPS];

   assign busy      = (state != ST_IDLE);
   assign accept    = in_valid && !busy;
   assign bit_last  = (bit_cnt == LAST_BIT);
   assign filt_done = (state == ST_FILT) && bit_last;

   always_comb begin
      for (int k = 0; k < TAPS; k++) x_slice[k] = xdl[k][bit_cnt];
   end

   // ---- filter path: one bit slice per cycle ----
   dalms_slice_sum #(.TAPS(TAPS), .WW(WW), .AW(AW)) u_slice (
      .wgt (wgt),
      .sel (x_slice),
      .sum (s_slice)
   );

   dalms_shift_acc #(.AW(AW)) u_facc (
      .clk    (clk),
      .rst    (rst),
      .clr    (accept),
      .en     (state == ST_FILT),
      .last   (bit_last),
      .addend (s_slice),
      .acc_d  (facc_d)
   );

   dalms_sat #(.IW(AW), .OW(DW)) u_ysat (
      .din  (facc_d),
      .dout (y_next)
   );

   assign e_wide = {d_q[DW-1], d_q} - {y_next[DW-1], y_next};

   dalms_sat #(.IW(DW+1), .OW(DW)) u_esat (
      .din  (e_wide),
      .dout (e_next)
   );

   // ---- update path: every tap forms err*x[k] bit-serially in parallel ----
   for (genvar k = 0; k < TAPS; k++) begin : g_upd
      logic signed [AW-1:0] addend;
      logic signed [AW-1:0] uacc_d;
      logic signed [AW-1:0] delta;
      logic signed [AW:0]   wsum;
      logic signed [WW-1:0] wsat;

      assign addend = x_slice[k] ? {{(AW-DW){out_err[DW-1]}}, out_err} : '0;

      dalms_shift_acc #(.AW(AW)) u_uacc (
         .clk    (clk),
         .rst    (rst),
         .clr    (filt_done),
         .en     (state == ST_UPD),
         .last   (bit_last),
         .addend (addend),
         .acc_d  (uacc_d)
      );

      assign delta    = uacc_d >>> MU_SHIFT;
      assign wsum     = {{(AW+1-WW){wgt[k][WW-1]}}, wgt[k]} + {delta[AW-1], delta};

      dalms_sat #(.IW(AW+1), .OW(WW)) u_wsat (
         .din  (wsum),
         .dout (wsat)
      );

      assign w_new[k] = wsat;
   end

   // ---- sequencing ----
   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= ST_IDLE;
         bit_cnt   <= '0;
         xdl       <= '0;
         wgt       <= '0;
         d_q       <= '0;
         out_valid <= 1'b0;
         out_y     <= '0;
         out_err   <= '0;
         overrun   <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         if (in_valid && busy) overrun <= 1'b1;
         case (state)
            ST_IDLE: begin
               if (in_valid) begin
                  xdl     <= {xdl[TAPS-2:0], in_sample};
                  d_q     <= in_desired;
                  bit_cnt <= '0;
                  state   <= ST_FILT;
               end
            end
            ST_FILT: begin
               if (bit_last) begin
                  out_y     <= y_next;
                  out_err   <= e_next;
                  out_valid <= 1'b1;
                  bit_cnt   <= '0;
                  state     <= ST_UPD;
               end else begin
                  bit_cnt <= bit_cnt + 1'b1;
               end
            end
            ST_UPD: begin
               if (bit_last) begin
                  for (int k = 0; k < TAPS; k++) wgt[k] <= w_new[k];
                  bit_cnt <= '0;
                  state   <= ST_IDLE;
               end else begin
                  bit_cnt <= bit_cnt + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid) else $error("valid longer than one cycle"); // R2
   AST_Y_HOLD: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> $stable(out_y)) else $error("output moved without valid"); // R2
   AST_W_FROZEN: assert property (@(posedge clk) disable iff (rst)
      (state == ST_FILT) |=> $stable(wgt)) else $error("weights moved while filtering"); // R5
   AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
      (in_valid && busy) |=> $stable(xdl)) else $error("busy sample entered delay line"); // R6
   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
      overrun |=> overrun) else $error("overrun flag cleared"); // R6
endmodule

// File: tb/dalms_fir_bench.sv
`timescale 1ns/1ps
module dalms_fir_bench;
   localparam int TAPS = 16;
   localparam int DW   = 16;
   localparam int MU   = 2;

   typedef struct {
      longint y;
      longint e;
      int     due;
      bit     sat;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic [DW-1:0] in_sample = '0;
   logic [DW-1:0] in_desired = '0;
   logic          out_valid;
   logic [DW-1:0] out_y;
   logic [DW-1:0] out_err;
   logic          overrun;

   int     checks = 0;
   int     fails = 0;
   int     cyc = 0;
   bit     prev_valid = 1'b0;
   bit     ended = 1'b0;
   longint mw [TAPS];
   longint mx [TAPS];
   exp_t   q [$];
   logic [31:0] seed = 32'h1234_5678;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dalms_fir #(.TAPS(TAPS), .DW(DW), .WW(16), .AW(24), .MU_SHIFT(MU)) u_dalms_fir (
      .clk        (clk),
      .rst        (rst),
      .in_valid   (in_valid),
      .in_sample  (in_sample),
      .in_desired (in_desired),
      .out_valid  (out_valid),
      .out_y      (out_y),
      .out_err    (out_err),
      .overrun    (overrun)
   );

   function automatic longint sat16(longint v);
      if (v > 32767)  return 32767;
      if (v < -32768) return -32768;
      return v;
   endfunction

   function automatic longint rnd16();
      seed = seed * 32'd1103515245 + 32'd12345;
      return longint'($signed(seed[30:15]));
   endfunction

   task automatic chk(bit ok, string tag, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   // reference from the requirements: push expected result, then adapt
   task automatic model(longint x, longint d, int acc_cyc);
      longint p, raw, y, e;
      exp_t   it;
      for (int k = TAPS - 1; k > 0; k--) mx[k] = mx[k-1];
      mx[0] = x;
      p = 0;
      for (int k = 0; k < TAPS; k++) p += mw[k] * mx[k];
      raw = p >>> 15;
      y = sat16(raw);
      e = sat16(d - y);
      it.y = y; it.e = e; it.due = acc_cyc + DW;
      it.sat = (raw != y) || (d - y != e);
      q.push_back(it);
      for (int k = 0; k < TAPS; k++) mw[k] = sat16(mw[k] + ((e * mx[k]) >>> (15 + MU)));
   endtask

   // called at a falling edge; returns gap falling edges after acceptance
   task automatic send(longint x, longint d, int gap);
      in_valid   = 1'b1;
      in_sample  = DW'(x);
      in_desired = DW'(d);
      @(negedge clk);
      in_valid = 1'b0;
      model(x, d, cyc);
      repeat (gap) @(negedge clk);
   endtask

   task automatic poke_busy(longint x);
      in_valid  = 1'b1;
      in_sample = DW'(x);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // monitor: scoreboard pop and compare
   always @(negedge clk) begin
      if (!rst) begin
         if (prev_valid) chk(!out_valid, "R2 pulse width", longint'(out_valid), 0);
         if (out_valid) begin
            if (q.size() == 0) begin
               chk(1'b0, "R2/R6 unexpected result", longint'($signed(out_y)), 0);
            end else begin
               exp_t it;
               it = q.pop_front();
               chk(cyc == it.due, "R2 result timing", cyc, it.due);
               chk(longint'($signed(out_y)) == it.y, it.sat ? "R8 saturated output" : "R3/R5 output",
                   longint'($signed(out_y)), it.y);
               chk(longint'($signed(out_err)) == it.e, it.sat ? "R8 saturated error" : "R4 error",
                   longint'($signed(out_err)), it.e);
            end
         end
         prev_valid = out_valid;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         fails++;
         $display("FAIL R2 watchdog expired actual=%0d expected=%0d", q.size(), 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < TAPS; k++) begin
         mw[k] = 0;
         mx[k] = 0;
      end
      repeat (5) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;

      // R1: reset state
      chk(out_valid == 1'b0, "R1 out_valid", longint'(out_valid), 0);
      chk(out_y == '0, "R1 out_y", longint'(out_y), 0);
      chk(out_err == '0, "R1 out_err", longint'(out_err), 0);
      chk(overrun == 1'b0, "R1 overrun", longint'(overrun), 0);

      // R1/R3/R4: first result with zero weights
      send(1000, 5000, 40);
      send(-2000, 3000, 40);

      // R3/R4/R5: assorted patterns
      for (int i = 0; i < 24; i++) send(rnd16(), rnd16(), 40);

      // R8: full-scale samples at the 200-cycle rate, sign slice exercised
      for (int i = 0; i < 10; i++) send((i % 2 == 0) ? -32768 : 32767, (i % 2 == 0) ? 16000 : -16000, 199);

      // R7/R8: minimum spacing with a driving desired value, output saturates
      for (int i = 0; i < 12; i++) send(32767, 32767, 32);

      // R6: samples during busy are dropped and flagged
      chk(overrun == 1'b0, "R6 overrun before busy input", longint'(overrun), 0);
      send(12345, -4000, 4);
      poke_busy(-7777);
      chk(overrun == 1'b1, "R6 overrun set", longint'(overrun), 1);
      repeat (26) @(negedge clk);
      poke_busy(22222);
      send(-321, 111, 40);
      for (int i = 0; i < 6; i++) send(rnd16(), rnd16(), 33);

      repeat (4 * DW) @(negedge clk);
      chk(q.size() == 0, "R2 all results produced", q.size(), 0);
      chk(overrun == 1'b1, "R6 overrun sticky", longint'(overrun), 1);

      if (!ended) begin
         ended = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule